// File: doc/BRIEF.md
# Low-Speed USB Receive Front End

This block turns the raw low-speed USB line into a stream of decoded data bits. It watches the two single-ended receivers and the differential receiver through a clock that runs at four times the bit rate. A small digital phase tracker re-centres the bit sampling point on every level change of the differential signal, so drift and edge jitter in the incoming stream do not move the sample out of its bit cell.

Once the synchronisation pattern has been seen, every sampled cell is NRZI-decoded, stuffed bits are dropped, and the surviving bits leave on `bit_o` with a one-cycle `bit_vld_o` strobe. Two serial CRC checkers run alongside. The low two bits of the packet identifier select which of the two checks applies. When the line stays in single-ended zero long enough, the block ends the packet and reports the CRC result and any bit-stuff violation. Header parsing, endpoint logic and the transmit path belong to neighbouring blocks.

Top module: `usbrx_front`

## Requirements
- R1: After reset, and until a sync pattern arrives, `pkt_active_o`, `bit_vld_o`, `eop_o`, `crc_err_o` and `stuff_err_o` are all 0.
- R2: The line levels are K (`dp_i`=1, `dm_i`=0, `diff_i`=1), J (`dp_i`=0, `dm_i`=1, `diff_i`=0) and SE0 (both single-ended inputs 0). The eight sampled cells K J K J K J K K start a packet: `pkt_active_o` rises and both error flags clear. None of these cells is passed on as data.
- R3: Inside a packet, a cell with the same level as the previous cell decodes to 1 and a cell with a different level decodes to 0. Each kept bit appears once on `bit_o` with `bit_vld_o` high for one cycle, in line order. Bits appear only while `pkt_active_o` is high.
- R4: Sampling re-aligns to every level change, so cells that end in a level change may last 3, 4 or 5 clock cycles and still decode correctly.
- R5: The last K of the sync counts as a decoded 1. After six decoded 1s in a row, the next cell is dropped and is not output.
- R6: If the dropped cell after six 1s decodes to 1, `stuff_err_o` is set. It holds until the next sync and does not change while no packet is active.
- R7: SE0 on two bit samples in a row inside a packet gives a single-cycle `eop_o` pulse. In the same cycle `pkt_active_o` falls.
- R8: SE0 while no packet is active produces no `eop_o` and no data bits.
- R9: If the first two decoded bits (the packet identifier bits 0 and 1) are 1,1, a 16-bit CRC (polynomial 0x8005, preset all ones) runs over every bit after the first eight. `crc_err_o` is set at end of packet unless the final register equals 0x800D.
- R10: If the first two decoded bits are 1 then 0 (identifier bits [1:0] = 01), a 5-bit CRC (polynomial 0x05, preset all ones) runs over the same bits. `crc_err_o` is set at end of packet unless the final register equals 0x0C.
- R11: For any other value of the identifier's low two bits, `crc_err_o` is 0 at end of packet.
- R12: `crc_err_o` changes only at end of packet (new result) or at sync (cleared). It holds its value between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| dp_i | input | 1 | Single-ended receiver, D+ line |
| dm_i | input | 1 | Single-ended receiver, D- line |
| diff_i | input | 1 | Differential receiver output, 1 = K |
| bit_o | output | 1 | Decoded data bit |
| bit_vld_o | output | 1 | One-cycle strobe qualifying `bit_o` |
| pkt_active_o | output | 1 | High from sync until end of packet |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| crc_err_o | output | 1 | CRC result of the last packet |
| stuff_err_o | output | 1 | Bit-stuff violation seen in the current or last packet |

## Verification
The hardest condition to reach from the ports is a sampling point that has to move. This happens when one cell is shortened or stretched by a clock cycle, and the next level change must pull the phase back before a long run of unchanged cells. The stimulus builds its packets from random bytes, with many all-ones bytes to force stuffing. Each cell that ends in a level change gets a random length of 3 to 5 cycles, while runs without a change keep the nominal length. The decoded stream must then match the sent bits exactly. Single-bit corruptions after the CRC has been computed, and a packet sent without stuffing, drive the two error flags.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    // Sampled line condition handed from the synchroniser to the decoder.
    typedef struct packed {
        logic se0;   // both single-ended receivers low
        logic lvl;   // differential level, 1 = K
    } line_t;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_BODY = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        CHK_NONE = 2'd0,
        CHK_C5   = 2'd1,
        CHK_C16  = 2'd2
    } chk_e;

    // Raw cell levels of the sync field, oldest cell in the MSB.
    localparam logic [7:0]  SYNC_LVLS  = 8'b1010_1011;
    localparam int          PID_BITS   = 8;
    localparam logic [4:0]  C5_POLY    = 5'h05;
    localparam logic [4:0]  C5_RES     = 5'h0C;
    localparam logic [15:0] C16_POLY   = 16'h8005;
    localparam logic [15:0] C16_RES    = 16'h800D;

    // Low two identifier bits decide which check applies.
    function automatic chk_e pid_check(input logic [1:0] pid_lo);
        chk_e r;
        unique case (pid_lo)
            2'b01:   r = CHK_C5;
            2'b11:   r = CHK_C16;
            default: r = CHK_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usbrx_sync.sv
module usbrx_sync
    import usbrx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  dp_i,
    input  logic  dm_i,
    input  logic  diff_i,
    output line_t line_o
);
    // Each stage holds {dp, dm, diff}; reset value is the idle J state.
    localparam logic [2:0] IDLE_J = 3'b010;

    logic [2:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= IDLE_J;
                else     stg[s] <= {dp_i, dm_i, diff_i};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= IDLE_J;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    always_comb begin
        line_o.se0 = ~stg[STAGES-1][2] & ~stg[STAGES-1][1];
        line_o.lvl = stg[STAGES-1][0];
    end

endmodule

// File: rtl/usbrx_dpll.sv
module usbrx_dpll #(
    parameter int OSR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic strobe_o
);
    localparam int            CW   = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] HALF = CW'(OSR / 2);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic          lvl_q;
    logic [CW-1:0] phase;
    logic          edge_seen;

    assign edge_seen = lvl_i ^ lvl_q;

    // A level change marks the start of a cell; restart the phase there.
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            phase <= '0;
        end else begin
            lvl_q <= lvl_i;
            if (edge_seen)          phase <= CW'(1);
            else if (phase == LAST) phase <= '0;
            else                    phase <= phase + CW'(1);
        end
    end

    assign strobe_o = (phase == HALF);

endmodule

// File: rtl/usbrx_crc.sv
module usbrx_crc #(
    parameter int           W    = 5,
    parameter logic [W-1:0] POLY = W'(5),
    parameter logic [W-1:0] RES  = W'(12)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic ok_o
);
    logic [W-1:0] crc;
    logic         fb;

    assign fb = crc[W-1] ^ din;

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '1;
        else if (en)    crc <= {crc[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end

    assign ok_o = (crc == RES);

endmodule

// File: rtl/usbrx_decode.sv
module usbrx_decode
    import usbrx_pkg::*;
#(
    parameter int STUFF_RUN = 6,
    parameter int EOP_BITS  = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  line_t line,
    input  logic  c5_ok,
    input  logic  c16_ok,
    output logic  crc_clr,
    output logic  crc_en,
    output logic  crc_bit,
    output logic  bit_o,
    output logic  bit_vld_o,
    output logic  pkt_active_o,
    output logic  eop_o,
    output logic  crc_err_o,
    output logic  stuff_err_o
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);
    localparam int EOP_W = $clog2(EOP_BITS + 1);
    localparam int NB_W  = $clog2(PID_BITS + 1);

    rx_state_e        state;
    logic [7:0]       hist;
    logic             prev_lvl;
    logic [RUN_W-1:0] ones;
    logic [EOP_W-1:0] se0_run;
    logic [NB_W-1:0]  nbits;
    logic [1:0]       pid_lo;

    logic [7:0] hist_nx;
    logic       sync_hit, nrzi, body_bit, is_stuff, take, eop_hit, crc_bad;
    chk_e       chk;

    always_comb begin
        hist_nx  = {hist[6:0], line.lvl & ~line.se0};
        sync_hit = strobe && (state == RX_HUNT) && !line.se0 && (hist_nx == SYNC_LVLS);
        nrzi     = (line.lvl == prev_lvl);
        body_bit = strobe && (state == RX_BODY) && !line.se0;
        is_stuff = (ones == RUN_W'(STUFF_RUN));
        take     = body_bit && !is_stuff;
        eop_hit  = strobe && (state == RX_BODY) && line.se0
                   && (se0_run == EOP_W'(EOP_BITS - 1));
        chk      = pid_check(pid_lo);
        crc_bad  = ((chk == CHK_C5) && !c5_ok) || ((chk == CHK_C16) && !c16_ok);
        crc_clr  = sync_hit;
        crc_en   = take && (nbits == NB_W'(PID_BITS));
        crc_bit  = nrzi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= RX_HUNT;
            hist         <= '0;
            prev_lvl     <= 1'b0;
            ones         <= '0;
            se0_run      <= '0;
            nbits        <= '0;
            pid_lo       <= '0;
            bit_o        <= 1'b0;
            bit_vld_o    <= 1'b0;
            pkt_active_o <= 1'b0;
            eop_o        <= 1'b0;
            crc_err_o    <= 1'b0;
            stuff_err_o  <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            eop_o     <= 1'b0;
            if (strobe) begin
                unique case (state)
                    RX_HUNT: begin
                        hist <= hist_nx;
                        if (sync_hit) begin
                            state        <= RX_BODY;
                            pkt_active_o <= 1'b1;
                            prev_lvl     <= 1'b1;
                            ones         <= RUN_W'(1);
                            se0_run      <= '0;
                            nbits        <= '0;
                            pid_lo       <= '0;
                            crc_err_o    <= 1'b0;
                            stuff_err_o  <= 1'b0;
                            hist         <= '0;
                        end
                    end
                    RX_BODY: begin
                        if (line.se0) begin
                            if (eop_hit) begin
                                state        <= RX_HUNT;
                                pkt_active_o <= 1'b0;
                                eop_o        <= 1'b1;
                                crc_err_o    <= crc_bad;
                                se0_run      <= '0;
                            end else begin
                                se0_run <= se0_run + EOP_W'(1);
                            end
                        end else begin
                            se0_run  <= '0;
                            prev_lvl <= line.lvl;
                            if (is_stuff) begin
                                ones <= '0;
                                if (nrzi) stuff_err_o <= 1'b1;
                            end else begin
                                bit_o     <= nrzi;
                                bit_vld_o <= 1'b1;
                                ones      <= nrzi ? ones + RUN_W'(1) : '0;
                                if (nbits < NB_W'(PID_BITS)) nbits <= nbits + NB_W'(1);
                                if (nbits < NB_W'(2))        pid_lo[nbits[0]] <= nrzi;
                            end
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/usbrx_front.sv
module usbrx_front
    import usbrx_pkg::*;
#(
    parameter int OSR         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STUFF_RUN   = 6,
    parameter int EOP_BITS    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dp_i,
    input  logic dm_i,
    input  logic diff_i,
    output logic bit_o,
    output logic bit_vld_o,
    output logic pkt_active_o,
    output logic eop_o,
    output logic crc_err_o,
    output logic stuff_err_o
);
    line_t line;
    logic  strobe;
    logic  crc_clr, crc_en, crc_bit, c5_ok, c16_ok;

    usbrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .dp_i   (dp_i),
        .dm_i   (dm_i),
        .diff_i (diff_i),
        .line_o (line)
    );

    usbrx_dpll #(.OSR(OSR)) u_dpll (
        .clk      (clk),
        .rst      (rst),
        .lvl_i    (line.lvl),
        .strobe_o (strobe)
    );

    usbrx_crc #(.W(5), .POLY(C5_POLY), .RES(C5_RES)) u_crc5 (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .en   (crc_en),
        .din  (crc_bit),
        .ok_o (c5_ok)
    );

    usbrx_crc #(.W(16), .POLY(C16_POLY), .RES(C16_RES)) u_crc16 (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .en   (crc_en),
        .din  (crc_bit),
        .ok_o (c16_ok)
    );

    usbrx_decode #(.STUFF_RUN(STUFF_RUN), .EOP_BITS(EOP_BITS)) u_dec (
        .clk          (clk),
        .rst          (rst),
        .strobe       (strobe),
        .line         (line),
        .c5_ok        (c5_ok),
        .c16_ok       (c16_ok),
        .crc_clr      (crc_clr),
        .crc_en       (crc_en),
        .crc_bit      (crc_bit),
        .bit_o        (bit_o),
        .bit_vld_o    (bit_vld_o),
        .pkt_active_o (pkt_active_o),
        .eop_o        (eop_o),
        .crc_err_o    (crc_err_o),
        .stuff_err_o  (stuff_err_o)
    );

endmodule

// File: rtl/usbrx_front_chk.sv
module usbrx_front_chk (
    input logic clk,
    input logic rst,
    input logic bit_vld_o,
    input logic pkt_active_o,
    input logic eop_o,
    input logic crc_err_o,
    input logic stuff_err_o
);
    AST_BIT_IN_PKT: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> pkt_active_o);                                   // R3

    AST_BIT_SPACED: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |=> !bit_vld_o);                                     // R4

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_active_o) |-> (!crc_err_o && !stuff_err_o));         // R2

    AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eop_o |=> !eop_o);                                             // R7

    AST_EOP_ENDS_PKT: assert property (@(posedge clk) disable iff (rst)
        eop_o |-> !pkt_active_o);                                      // R7

    AST_EOP_NEEDS_PKT: assert property (@(posedge clk) disable iff (rst)
        eop_o |-> $past(pkt_active_o));                                // R8

    AST_STUFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pkt_active_o |-> $stable(stuff_err_o));                       // R6

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!eop_o && !$rose(pkt_active_o)) |-> $stable(crc_err_o));      // R12

endmodule

bind usbrx_front usbrx_front_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_vld_o    (bit_vld_o),
    .pkt_active_o (pkt_active_o),
    .eop_o        (eop_o),
    .crc_err_o    (crc_err_o),
    .stuff_err_o  (stuff_err_o)
);

// File: tb/usbrx_front_tb_top.sv
module usbrx_front_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dp = 1'b0, dm = 1'b1, diff = 1'b0;
    logic bit_o, bit_vld_o, pkt_active_o, eop_o, crc_err_o, stuff_err_o;

    int checks = 0;
    int fails  = 0;

    bit rx_q[$];
    bit pkt_bits[$];
    bit lv_q[$];
    int eop_cnt = 0;
    bit crc_at_eop = 0, stuff_at_eop = 0, saw_active = 0;

    always #5 clk = ~clk;

    usbrx_front dut_i (
        .clk          (clk),
        .rst          (rst),
        .dp_i         (dp),
        .dm_i         (dm),
        .diff_i       (diff),
        .bit_o        (bit_o),
        .bit_vld_o    (bit_vld_o),
        .pkt_active_o (pkt_active_o),
        .eop_o        (eop_o),
        .crc_err_o    (crc_err_o),
        .stuff_err_o  (stuff_err_o)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_vld_o)    rx_q.push_back(bit_o);
            if (pkt_active_o) saw_active = 1'b1;
            if (eop_o) begin
                eop_cnt++;
                crc_at_eop   = crc_err_o;
                stuff_at_eop = stuff_err_o;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // 0 = J, 1 = K, 2 = SE0
    task automatic drive(input int code, input int n);
        repeat (n) begin
            @(negedge clk);
            case (code)
                0:       {dp, dm, diff} = 3'b010;
                1:       {dp, dm, diff} = 3'b101;
                default: {dp, dm, diff} = 3'b000;
            endcase
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) pkt_bits.push_back(b[i]);
    endtask

    // Serial CRC over bits after the identifier, inverted remainder appended MSB first.
    task automatic append_crc(input int w);
        logic [15:0] c, poly, mask;
        logic        fb;
        c    = 16'hFFFF;
        poly = (w == 5) ? 16'h0005 : 16'h8005;
        mask = (w == 5) ? 16'h001F : 16'hFFFF;
        c    = c & mask;
        for (int i = 8; i < pkt_bits.size(); i++) begin
            fb = c[w-1] ^ pkt_bits[i];
            c  = ((c << 1) ^ (fb ? poly : 16'h0)) & mask;
        end
        for (int k = w - 1; k >= 0; k--) pkt_bits.push_back(~c[k]);
    endtask

    // kind 0 = token, 1 = data, 2 = handshake
    task automatic build(input int kind, input int nbytes, input bit all_ff);
        pkt_bits.delete();
        case (kind)
            0: begin
                push_byte(8'hE1);
                for (int i = 0; i < 11; i++) pkt_bits.push_back(1'($urandom_range(0, 1)));
                append_crc(5);
            end
            1: begin
                push_byte(8'hC3);
                for (int i = 0; i < nbytes; i++)
                    push_byte((all_ff || $urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom));
                append_crc(16);
            end
            default: push_byte(8'hD2);
        endcase
    endtask

    task automatic corrupt();
        int idx;
        idx = 8 + $urandom_range(0, pkt_bits.size() - 9);
        pkt_bits[idx] = ~pkt_bits[idx];
    endtask

    task automatic send(input bit jitter, input bit do_stuff);
        bit cur;
        int ones, len;
        lv_q.delete();
        lv_q = '{1, 0, 1, 0, 1, 0, 1, 1};
        cur  = 1'b1;
        ones = 1;
        foreach (pkt_bits[i]) begin
            if (pkt_bits[i] == 1'b0) begin cur = ~cur; ones = 0; end
            else ones++;
            lv_q.push_back(cur);
            if (do_stuff && ones == 6) begin
                cur = ~cur;
                lv_q.push_back(cur);
                ones = 0;
            end
        end
        rx_q.delete();
        eop_cnt    = 0;
        saw_active = 1'b0;
        drive(0, 4 * (2 + $urandom_range(0, 3)));
        for (int i = 0; i < lv_q.size(); i++) begin
            len = 4;
            if (jitter && (i + 1 < lv_q.size()) && (lv_q[i+1] != lv_q[i]))
                len = 3 + $urandom_range(0, 2);
            drive(lv_q[i] ? 1 : 0, len);
        end
        drive(2, 8);
        drive(0, 8);
        repeat (4) @(negedge clk);
    endtask

    function automatic bit bits_match();
        if (rx_q.size() != pkt_bits.size()) return 1'b0;
        foreach (pkt_bits[i]) if (rx_q[i] != pkt_bits[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check_packet(input string tag, input bit exp_crc);
        check(bits_match(), {tag, " R3 R5 decoded bits"}, rx_q.size(), pkt_bits.size());
        check(eop_cnt == 1, {tag, " R7 eop count"}, eop_cnt, 1);
        check(saw_active && !pkt_active_o, {tag, " R2 active window"}, int'(pkt_active_o), 0);
        check(crc_at_eop == exp_crc, {tag, " R9 R10 R11 crc flag"}, int'(crc_at_eop), int'(exp_crc));
        check(stuff_at_eop == 1'b0, {tag, " R5 no stuff error"}, int'(stuff_at_eop), 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int kind;
        bit bad;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check({pkt_active_o, bit_vld_o, eop_o, crc_err_o, stuff_err_o} == 5'b0,
              "R1 outputs after reset",
              int'({pkt_active_o, bit_vld_o, eop_o, crc_err_o, stuff_err_o}), 0);

        // R8 SE0 while idle
        rx_q.delete();
        eop_cnt = 0;
        drive(2, 16);
        drive(0, 12);
        check(eop_cnt == 0 && rx_q.size() == 0, "R8 idle SE0 ignored", eop_cnt + rx_q.size(), 0);
        check(!pkt_active_o, "R8 idle stays inactive", int'(pkt_active_o), 0);

        // R9 R5 data packet full of ones, no jitter
        build(1, 8, 1'b1);
        send(1'b0, 1'b1);
        check_packet("data_ff R9", 1'b0);

        // R10 token, good
        build(0, 0, 1'b0);
        send(1'b0, 1'b1);
        check_packet("token R10", 1'b0);

        // R10 token, corrupted
        build(0, 0, 1'b0);
        corrupt();
        send(1'b0, 1'b1);
        check_packet("token_bad R10", 1'b1);

        // R9 data corrupted, then R12 hold between packets
        build(1, 5, 1'b0);
        corrupt();
        send(1'b1, 1'b1);
        check_packet("data_bad R9", 1'b1);
        drive(0, 40);
        check(crc_err_o == 1'b1, "R12 crc flag held while idle", int'(crc_err_o), 1);

        // R11 handshake: no CRC check, flag cleared at sync
        build(2, 0, 1'b0);
        send(1'b1, 1'b1);
        check_packet("ack R11", 1'b0);
        check(crc_err_o == 1'b0, "R12 crc flag replaced", int'(crc_err_o), 0);

        // R9 empty data payload
        build(1, 0, 1'b0);
        send(1'b0, 1'b1);
        check_packet("data_empty R9", 1'b0);

        // R6 stuffing missing
        build(1, 4, 1'b1);
        send(1'b0, 1'b0);
        check(stuff_at_eop == 1'b1, "R6 stuff error at eop", int'(stuff_at_eop), 1);
        drive(0, 30);
        check(stuff_err_o == 1'b1, "R6 stuff flag held while idle", int'(stuff_err_o), 1);

        // R4 random packets with edge jitter
        for (int n = 0; n < 24; n++) begin
            kind = $urandom_range(0, 2);
            build(kind, $urandom_range(0, 8), 1'b0);
            bad = (kind != 2) && ($urandom_range(0, 3) == 0);
            if (bad) corrupt();
            send(1'b1, 1'b1);
            check_packet("random R4", bad);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule